// File: doc/BRIEF.md
# Instruction Control Decoder with Branch and Trap Overrides

This block turns the 6-bit operation field of a fetched instruction into the control word that steers a simple 32-bit load/store datapath: which value the program counter takes next, which register is written and from which source, whether memory is written, which ALU function runs and which operands feed it. A combinational table supplies the base control word. Three overrides are then applied on top of it, from weakest to strongest: conditional-branch resolution from the register-zero flag, a trap for a pending interrupt request, and reset.

Interrupt requests are caught in a sticky pending flag that is owned by this block. A pending request is taken only when the datapath is about to commit an instruction (step enable high) and the processor runs in user mode (PC bit 31 low). A taken interrupt replaces the current instruction's controls so that the return address is saved and execution jumps to the interrupt vector. Reset has the last word and always keeps memory from being written.

Top module: `op_ctrl_decode`

## Requirements
- R1: Register and constant ALU forms decode as follows. ADD (100000) and CMPEQ (100100) use the register operand for B (b_sel=0). ADDC (110000) and CMPEQC (110100) use the constant (b_sel=1). All four give pc_sel=000, wa_sel=0, wd_sel=01 (ALU), rf_we=1, mem_we=0, a_sel=0 and ra2_sel=0. alu_fn is 000000 for the adds and 110011 for the compares.
- R2: LD (011000) gives alu_fn=000000, a_sel=0, b_sel=1, wd_sel=10 (memory) and rf_we=1. LDR (011111) gives alu_fn=011010 (pass A), a_sel=1 (PC-relative address), b_sel=1, wd_sel=10 and rf_we=1. Both give pc_sel=000, wa_sel=0, ra2_sel=0 and mem_we=0.
- R3: ST (011001) gives mem_we=1, rf_we=0, ra2_sel=1, b_sel=1, a_sel=0, alu_fn=000000, pc_sel=000, wa_sel=0 and wd_sel=00. No other opcode ever yields mem_we=1.
- R4: JMP (011011) gives pc_sel=010, wd_sel=00 (PC+4), rf_we=1, wa_sel=0 and mem_we=0, with the ALU fields all zero.
- R5: BEQ (011101) gives pc_sel=001 when zero=1 and 000 when zero=0. In both cases it writes PC+4 (wd_sel=00, rf_we=1, wa_sel=0).
- R6: BNE (011110) gives pc_sel=001 when zero=0 and 000 when zero=1. The other fields are the same as for BEQ.
- R7: Any opcode not listed above gives pc_sel=011, wa_sel=1 (exception register), wd_sel=00, rf_we=1 and mem_we=0, with the ALU fields all zero.
- R8: A request on irq sets the pending flag at the next rising edge. The flag stays set after irq falls and stays set until the interrupt is taken or reset is applied.
- R9: The interrupt is taken in a cycle where the pending flag is set, step=1, pc_msb=0 and rst=0. A taken interrupt forces pc_sel=100, wa_sel=1, wd_sel=00, rf_we=1 and mem_we=0, whatever the opcode or zero flag.
- R10: While pc_msb=1 (supervisor mode), a pending request is not taken and changes no output. It stays pending and is taken in the first later cycle that meets R9.
- R11: While rst=1, mem_we=0 and no interrupt is taken. All other fields follow the table and branch resolution. A reset cycle clears the pending flag.
- R12: Taking an interrupt clears the pending flag. If irq is high in the same cycle as the take, the flag is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; highest-priority override |
| opcode | input | 6 | Operation field of the current instruction |
| zero | input | 1 | High when the first register operand equals zero |
| pc_msb | input | 1 | PC bit 31: 1 = supervisor mode, 0 = user mode |
| irq | input | 1 | Interrupt request |
| step | input | 1 | High in the cycle where the instruction commits |
| pc_sel | output | 3 | Next-PC select: 000 PC+4, 001 branch target, 010 jump target, 011 illegal trap, 100 interrupt vector |
| wa_sel | output | 1 | Write-address select: 0 instruction field, 1 exception register |
| wd_sel | output | 2 | Write-data select: 00 PC+4, 01 ALU result, 10 memory read data |
| rf_we | output | 1 | Register file write enable |
| mem_we | output | 1 | Memory write enable |
| alu_fn | output | 6 | ALU function code |
| a_sel | output | 1 | ALU A select: 0 register, 1 PC-relative address |
| b_sel | output | 1 | ALU B select: 0 register, 1 sign-extended constant |
| ra2_sel | output | 1 | Second read address select: 0 rb field, 1 rc field |

## Verification
The only internal state is the pending interrupt flag, so it is the only state that can go wrong. A flag that is lost, stuck or cleared at the wrong time shows up at the ports in the first cycle where step is high in user mode: either the trap controls (pc_sel=100, wa_sel=1) appear when the instruction's own controls were due, or they are missing. The bench keeps its own model of that flag. It checks every cycle under random request, step, mode and reset patterns, and adds directed cases for a request held off by supervisor mode, a request arriving in the same cycle as a take, and a flag cleared by reset. Decode errors show up in the same cycle as the opcode, because the table and the branch logic have no registers.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int PCS_W = 3;
    localparam int WDS_W = 2;

    // operation field encodings
    localparam logic [OP_W-1:0] OPC_ADD    = 6'b100000;
    localparam logic [OP_W-1:0] OPC_CMPEQ  = 6'b100100;
    localparam logic [OP_W-1:0] OPC_ADDC   = 6'b110000;
    localparam logic [OP_W-1:0] OPC_CMPEQC = 6'b110100;
    localparam logic [OP_W-1:0] OPC_LD     = 6'b011000;
    localparam logic [OP_W-1:0] OPC_ST     = 6'b011001;
    localparam logic [OP_W-1:0] OPC_JMP    = 6'b011011;
    localparam logic [OP_W-1:0] OPC_BEQ    = 6'b011101;
    localparam logic [OP_W-1:0] OPC_BNE    = 6'b011110;
    localparam logic [OP_W-1:0] OPC_LDR    = 6'b011111;

    // next-PC source
    localparam logic [PCS_W-1:0] NPC_SEQ   = 3'b000;
    localparam logic [PCS_W-1:0] NPC_BR    = 3'b001;
    localparam logic [PCS_W-1:0] NPC_JMP   = 3'b010;
    localparam logic [PCS_W-1:0] NPC_ILL   = 3'b011;
    localparam logic [PCS_W-1:0] NPC_IRQ   = 3'b100;

    // write-data source
    localparam logic [WDS_W-1:0] WD_LINK   = 2'b00;
    localparam logic [WDS_W-1:0] WD_ALU    = 2'b01;
    localparam logic [WDS_W-1:0] WD_MEM    = 2'b10;

    // ALU functions used by the table
    localparam logic [FN_W-1:0] FN_ADD     = 6'b000000;
    localparam logic [FN_W-1:0] FN_CMPEQ   = 6'b110011;
    localparam logic [FN_W-1:0] FN_PASSA   = 6'b011010;

    typedef struct packed {
        logic [PCS_W-1:0] pc_sel;
        logic             wa_sel;
        logic [WDS_W-1:0] wd_sel;
        logic             rf_we;
        logic             mem_we;
        logic [FN_W-1:0]  alu_fn;
        logic             a_sel;
        logic             b_sel;
        logic             ra2_sel;
    } ctl_t;

    function automatic ctl_t ctl_alu(input logic [FN_W-1:0] fn, input logic use_const);
        ctl_t c;
        c         = '0;
        c.pc_sel  = NPC_SEQ;
        c.wd_sel  = WD_ALU;
        c.rf_we   = 1'b1;
        c.alu_fn  = fn;
        c.b_sel   = use_const;
        return c;
    endfunction

    function automatic ctl_t ctl_link(input logic [PCS_W-1:0] npc, input logic to_xreg);
        ctl_t c;
        c         = '0;
        c.pc_sel  = npc;
        c.wa_sel  = to_xreg;
        c.wd_sel  = WD_LINK;
        c.rf_we   = 1'b1;
        return c;
    endfunction

    function automatic logic is_branch(input logic [OP_W-1:0] op);
        return (op == OPC_BEQ) || (op == OPC_BNE);
    endfunction

endpackage

// File: rtl/ctl_table.sv
module ctl_table
    import ctl_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output ctl_t            ctl
);

    always_comb begin
        unique case (opcode)
            OPC_ADD:    ctl = ctl_alu(FN_ADD,   1'b0);
            OPC_ADDC:   ctl = ctl_alu(FN_ADD,   1'b1);
            OPC_CMPEQ:  ctl = ctl_alu(FN_CMPEQ, 1'b0);
            OPC_CMPEQC: ctl = ctl_alu(FN_CMPEQ, 1'b1);
            OPC_LD: begin
                ctl        = ctl_alu(FN_ADD, 1'b1);
                ctl.wd_sel = WD_MEM;
            end
            OPC_LDR: begin
                ctl        = ctl_alu(FN_PASSA, 1'b1);
                ctl.a_sel  = 1'b1;
                ctl.wd_sel = WD_MEM;
            end
            OPC_ST: begin
                ctl         = ctl_alu(FN_ADD, 1'b1);
                ctl.wd_sel  = WD_LINK;
                ctl.rf_we   = 1'b0;
                ctl.mem_we  = 1'b1;
                ctl.ra2_sel = 1'b1;
            end
            OPC_JMP:    ctl = ctl_link(NPC_JMP, 1'b0);
            OPC_BEQ,
            OPC_BNE:    ctl = ctl_link(NPC_SEQ, 1'b0);
            default:    ctl = ctl_link(NPC_ILL, 1'b1);
        endcase
    end

endmodule

// File: rtl/ctl_branch.sv
module ctl_branch
    import ctl_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic            zero,
    input  ctl_t            ctl_in,
    output ctl_t            ctl_out
);

    logic taken;

    always_comb begin
        taken = 1'b0;
        if (opcode == OPC_BEQ) taken = zero;
        if (opcode == OPC_BNE) taken = !zero;
        ctl_out = ctl_in;
        if (is_branch(opcode))
            ctl_out.pc_sel = taken ? NPC_BR : NPC_SEQ;
    end

endmodule

// File: rtl/ctl_irq_latch.sv
module ctl_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic irq,
    input  logic step,
    input  logic pc_msb,
    output logic take
);

    logic pend_q;

    assign take = pend_q && step && !pc_msb && !rst;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else
            pend_q <= irq || (pend_q && !take);
    end

    // R10
    supervisor_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        pc_msb |-> !take);

    // R12
    clear_on_take_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !irq) |=> !pend_q);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !take) |=> pend_q);

endmodule

// File: rtl/op_ctrl_decode.sv
module op_ctrl_decode
    import ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode,
    input  logic              zero,
    input  logic              pc_msb,
    input  logic              irq,
    input  logic              step,
    output logic [PCS_W-1:0]  pc_sel,
    output logic              wa_sel,
    output logic [WDS_W-1:0]  wd_sel,
    output logic              rf_we,
    output logic              mem_we,
    output logic [FN_W-1:0]   alu_fn,
    output logic              a_sel,
    output logic              b_sel,
    output logic              ra2_sel
);

    ctl_t base_ctl;
    ctl_t br_ctl;
    ctl_t fin_ctl;
    logic irq_take;

    ctl_table u_table (
        .opcode (opcode),
        .ctl    (base_ctl)
    );

    ctl_branch u_branch (
        .opcode  (opcode),
        .zero    (zero),
        .ctl_in  (base_ctl),
        .ctl_out (br_ctl)
    );

    ctl_irq_latch u_irq (
        .clk    (clk),
        .rst    (rst),
        .irq    (irq),
        .step   (step),
        .pc_msb (pc_msb),
        .take   (irq_take)
    );

    always_comb begin
        fin_ctl = br_ctl;
        if (irq_take) begin
            fin_ctl.pc_sel = NPC_IRQ;
            fin_ctl.wa_sel = 1'b1;
            fin_ctl.wd_sel = WD_LINK;
            fin_ctl.rf_we  = 1'b1;
            fin_ctl.mem_we = 1'b0;
        end
        if (rst)
            fin_ctl.mem_we = 1'b0;
    end

    assign pc_sel  = fin_ctl.pc_sel;
    assign wa_sel  = fin_ctl.wa_sel;
    assign wd_sel  = fin_ctl.wd_sel;
    assign rf_we   = fin_ctl.rf_we;
    assign mem_we  = fin_ctl.mem_we;
    assign alu_fn  = fin_ctl.alu_fn;
    assign a_sel   = fin_ctl.a_sel;
    assign b_sel   = fin_ctl.b_sel;
    assign ra2_sel = fin_ctl.ra2_sel;

    // R11
    always_comb begin
        if (rst) rst_no_store_chk: assert (!mem_we);
    end

    // R3
    store_only_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (opcode == OPC_ST));

    // R9
    trap_fields_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (pc_sel == NPC_IRQ && wa_sel && rf_we && !mem_we && wd_sel == WD_LINK));

    // R5
    beq_resolve_chk: assert property (@(posedge clk) disable iff (rst)
        (opcode == OPC_BEQ && !irq_take) |-> (pc_sel == (zero ? NPC_BR : NPC_SEQ)));

    // R6
    bne_resolve_chk: assert property (@(posedge clk) disable iff (rst)
        (opcode == OPC_BNE && !irq_take) |-> (pc_sel == (zero ? NPC_SEQ : NPC_BR)));

endmodule

// File: tb/op_ctrl_decode_tb.sv
module op_ctrl_decode_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] opcode;
    logic       zero, pc_msb, irq, step;
    logic [2:0] pc_sel;
    logic       wa_sel;
    logic [1:0] wd_sel;
    logic       rf_we, mem_we;
    logic [5:0] alu_fn;
    logic       a_sel, b_sel, ra2_sel;

    int n_chk  = 0;
    int n_fail = 0;
    logic m_pend = 1'b0;

    always #5 clk = ~clk;

    op_ctrl_decode u_dut (
        .clk(clk), .rst(rst), .opcode(opcode), .zero(zero), .pc_msb(pc_msb),
        .irq(irq), .step(step), .pc_sel(pc_sel), .wa_sel(wa_sel), .wd_sel(wd_sel),
        .rf_we(rf_we), .mem_we(mem_we), .alu_fn(alu_fn), .a_sel(a_sel),
        .b_sel(b_sel), .ra2_sel(ra2_sel)
    );

    // packed order: pc_sel(3) wa(1) wd(2) rf_we(1) mem_we(1) fn(6) a(1) b(1) ra2(1)
    function automatic logic [16:0] pack(input logic [2:0] p, input logic w, input logic [1:0] d,
                                         input logic rw, input logic mw, input logic [5:0] f,
                                         input logic a, input logic b, input logic r2);
        return {p, w, d, rw, mw, f, a, b, r2};
    endfunction

    function automatic logic [16:0] exp_ctl(input logic [5:0] op, input logic z, input logic tk,
                                            input logic rs);
        logic [16:0] e;
        case (op)
            6'b100000: e = pack(3'b000, 0, 2'b01, 1, 0, 6'b000000, 0, 0, 0);
            6'b110000: e = pack(3'b000, 0, 2'b01, 1, 0, 6'b000000, 0, 1, 0);
            6'b100100: e = pack(3'b000, 0, 2'b01, 1, 0, 6'b110011, 0, 0, 0);
            6'b110100: e = pack(3'b000, 0, 2'b01, 1, 0, 6'b110011, 0, 1, 0);
            6'b011000: e = pack(3'b000, 0, 2'b10, 1, 0, 6'b000000, 0, 1, 0);
            6'b011111: e = pack(3'b000, 0, 2'b10, 1, 0, 6'b011010, 1, 1, 0);
            6'b011001: e = pack(3'b000, 0, 2'b00, 0, 1, 6'b000000, 0, 1, 1);
            6'b011011: e = pack(3'b010, 0, 2'b00, 1, 0, 6'b000000, 0, 0, 0);
            6'b011101: e = pack(z ? 3'b001 : 3'b000, 0, 2'b00, 1, 0, 6'b0, 0, 0, 0);
            6'b011110: e = pack(z ? 3'b000 : 3'b001, 0, 2'b00, 1, 0, 6'b0, 0, 0, 0);
            default:   e = pack(3'b011, 1, 2'b00, 1, 0, 6'b000000, 0, 0, 0);
        endcase
        if (tk) begin
            e[16:14] = 3'b100;
            e[13]    = 1'b1;
            e[12:11] = 2'b00;
            e[10]    = 1'b1;
            e[9]     = 1'b0;
        end
        if (rs) e[9] = 1'b0;
        return e;
    endfunction

    function automatic string tag_of(input logic [5:0] op, input logic tk, input logic rs);
        if (rs) return "R11";
        if (tk) return "R9";
        case (op)
            6'b100000, 6'b110000, 6'b100100, 6'b110100: return "R1";
            6'b011000, 6'b011111: return "R2";
            6'b011001: return "R3";
            6'b011011: return "R4";
            6'b011101: return "R5";
            6'b011110: return "R6";
            default:   return "R7";
        endcase
    endfunction

    task automatic cyc(input logic [5:0] op, input logic z, input logic msb, input logic rq,
                       input logic st, input logic rs, input string tag);
        logic        tk;
        logic [16:0] e, got;
        string       t;
        @(negedge clk);
        opcode = op; zero = z; pc_msb = msb; irq = rq; step = st; rst = rs;
        #1;
        tk  = m_pend && st && !msb && !rs;
        e   = exp_ctl(op, z, tk, rs);
        got = {pc_sel, wa_sel, wd_sel, rf_we, mem_we, alu_fn, a_sel, b_sel, ra2_sel};
        t   = (tag == "") ? tag_of(op, tk, rs) : tag;
        n_chk++;
        if (got !== e) begin
            n_fail++;
            $display("FAIL %s op=%b z=%0b pend=%0b: got %b expected %b", t, op, z, m_pend, got, e);
        end
        @(posedge clk);
        m_pend = rs ? 1'b0 : (rq || (m_pend && !tk));
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [5:0] ops [10];
        void'($urandom(32'd1234));
        ops = '{6'b100000, 6'b110000, 6'b100100, 6'b110100, 6'b011000,
                6'b011111, 6'b011001, 6'b011011, 6'b011101, 6'b011110};
        rst = 1; opcode = 6'b011001; zero = 0; pc_msb = 0; irq = 0; step = 0;
        // reset state: store held off (R11), irq during reset does not set latch
        cyc(6'b011001, 0, 0, 1, 1, 1, "R11");
        cyc(6'b011001, 0, 0, 0, 1, 1, "R11");
        cyc(6'b011001, 0, 0, 0, 1, 0, "R3");
        for (int i = 0; i < 10; i++) begin
            cyc(ops[i], 0, 0, 0, 1, 0, "");
            cyc(ops[i], 1, 0, 0, 1, 0, "");
        end
        cyc(6'b000001, 0, 0, 0, 1, 0, "R7");
        cyc(6'b111111, 1, 0, 0, 1, 0, "R7");
        // sticky latch with step low, then taken
        cyc(6'b011001, 0, 0, 1, 0, 0, "R8");
        cyc(6'b011001, 0, 0, 0, 0, 0, "R8");
        cyc(6'b011001, 0, 0, 0, 1, 0, "R9");
        cyc(6'b011001, 0, 0, 0, 1, 0, "R12");
        // supervisor mode holds the request off
        cyc(6'b011101, 1, 1, 1, 1, 0, "R10");
        cyc(6'b011101, 1, 1, 0, 1, 0, "R10");
        cyc(6'b011101, 1, 0, 0, 1, 0, "R10");
        cyc(6'b011101, 1, 0, 0, 1, 0, "R12");
        // request in the same cycle as a take stays pending
        cyc(6'b100000, 0, 0, 1, 1, 0, "R8");
        cyc(6'b100000, 0, 0, 1, 1, 0, "R12");
        cyc(6'b100000, 0, 0, 0, 1, 0, "R12");
        cyc(6'b100000, 0, 0, 0, 1, 0, "R12");
        // reset clears a pending request
        cyc(6'b100000, 0, 0, 1, 0, 0, "R8");
        cyc(6'b011001, 0, 0, 0, 1, 1, "R11");
        cyc(6'b011001, 0, 0, 0, 1, 0, "R11");
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] op;
            op = ($urandom % 4 == 0) ? 6'($urandom) : ops[$urandom % 10];
            cyc(op, 1'($urandom), ($urandom % 4) == 0, ($urandom % 8) == 0,
                1'($urandom), ($urandom % 50) == 0, "");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule